// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block scans a 40-segment by 8-common liquid-crystal panel at 1/8 duty with 1/5 bias. For every panel pin it produces a 3-bit level code, and an external analog switch uses that code to pick one of six bias voltages. The codes run from 0 for GND up to 5 for VDD, in fifths. The block reads its pixel bits through a read port into the 4-bit-wide display region of a data RAM. Each step of the common-scan enable moves the selection to the next common. A halt input blanks the panel.

Each segment owns two adjacent RAM nibbles at the top of the address space. Segment 0 uses FFH and FEH, segment 1 uses FDH and FCH, and so on downward to B0H. During one scan interval the block fetches, one nibble per clock, the 40 bits that the next common needs. It holds them in a row buffer. On the next scan step it shows them. The drive polarity flips each frame, so the panel sees no net DC.

Top module: `lcd_mux_driver`

## Requirements
- R1: While reset is high, and from reset until the first scan_en pulse, every common and segment code is 5 (VDD). Nothing is assumed about the RAM contents.
- R2: For segment s, the bit for common c is bit (c mod 4) of the nibble at address FFH-2s when c is 4 to 7, and at address FFH-2s-1 when c is 0 to 3. ram_rdata returns the nibble one clock after ram_raddr presents its address.
- R3: Each scan_en pulse selects the next common in the order 0,1,...,7,0. The first pulse after reset selects common 0. The output codes change one clock after the edge that samples the pulse.
- R4: The selected common is driven with code 5 in even frames and code 0 in odd frames. Every other common is driven with code 1 in even frames and code 4 in odd frames.
- R5: An on pixel (bit 1) drives its segment with code 0 in even frames and code 5 in odd frames. An off pixel (bit 0) drives it with code 3 in even frames and code 2 in odd frames.
- R6: The frame that begins at the first scan_en pulse is even. Parity toggles each time the selection wraps from common 7 to common 0.
- R7: One clock after blank_i goes high, every code is 5. Scan steps taken while blanked still advance the common selection and the frame parity. After release, the outputs show the current common.
- R8: No code ever exceeds 5. ram_raddr always lies within B0H..FFH.
- R9: scan_en pulses must be at least 43 clocks apart. If the RAM changes while no fetch is in progress, the change appears at the second scan step after it, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | One-clock pulse per common-scan step |
| blank_i | input | 1 | Halt/blank: forces all outputs to VDD |
| ram_rdata | input | 4 | Display RAM read data, one clock after the address |
| ram_raddr | output | 8 | Display RAM read address |
| com_lvl | output | 24 | Level codes for commons, common c at bits [3c+2:3c] |
| seg_lvl | output | 120 | Level codes for segments, segment s at bits [3s+2:3s] |

## Verification
On every cycle the assertions check the following:
- the code range and the address window;
- that exactly one common sits at a selected level while the panel is shown;
- that the common index and parity hold between steps and parity flips only on a wrap;
- the forced VDD after blank;
- the spacing rule between a scan step and the row fetch.

Only the bench scenarios can show four further behaviours:
- the nibble-to-pixel mapping across all 40 segments;
- the exact even and odd waveform codes;
- the one-step lag of a RAM update;
- that a blanked interval leaves the scan position intact.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_GND = 3'd0;
  localparam lvl_t LVL_1F  = 3'd1;
  localparam lvl_t LVL_2F  = 3'd2;
  localparam lvl_t LVL_3F  = 3'd3;
  localparam lvl_t LVL_4F  = 3'd4;
  localparam lvl_t LVL_VDD = 3'd5;

  // Common drive: selected pin swings rail to rail, others sit near the rail opposite
  function automatic lvl_t com_code(input logic sel, input logic odd);
    if (sel) return odd ? LVL_GND : LVL_VDD;
    return odd ? LVL_4F : LVL_1F;
  endfunction

  // Segment drive: on pixels oppose the selected common, off pixels stay mid-band
  function automatic lvl_t seg_code(input logic on, input logic odd);
    if (on) return odd ? LVL_VDD : LVL_GND;
    return odd ? LVL_2F : LVL_3F;
  endfunction
endpackage

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch #(
  parameter int NUM_SEG  = 40,
  parameter int NUM_COM  = 8,
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 8,
  parameter int DISP_TOP = 255,
  localparam int SEG_W   = $clog2(NUM_SEG),
  localparam int COM_W   = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COM_W-1:0]   target_com,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [ADDR_W-1:0]  ram_raddr,
  output logic               busy_o,
  output logic [NUM_SEG-1:0] row
);
  localparam int NIBS   = NUM_COM / DATA_W;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int LOW_AD = DISP_TOP - NUM_SEG * NIBS + 1;

  logic             issuing;
  logic [SEG_W-1:0] seg_cnt, idx0, idx1;
  logic [COM_W-1:0] tcom;
  logic             v0, v1;
  logic [ADDR_W-1:0] issue_addr;
  logic [BIT_W-1:0]  bit_sel;

  always_comb begin
    issue_addr = ADDR_W'(DISP_TOP - int'(seg_cnt) * NIBS - (NIBS - 1) + int'(tcom) / DATA_W);
    bit_sel    = BIT_W'(int'(tcom) % DATA_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing   <= 1'b0;
      seg_cnt   <= '0;
      tcom      <= '0;
      v0        <= 1'b0;
      v1        <= 1'b0;
      idx0      <= '0;
      idx1      <= '0;
      row       <= '0;
      ram_raddr <= ADDR_W'(DISP_TOP);
    end else begin
      v1   <= v0;
      idx1 <= idx0;
      if (v1) row[idx1] <= ram_rdata[bit_sel];
      if (start) begin
        issuing <= 1'b1;
        seg_cnt <= '0;
        tcom    <= target_com;
        v0      <= 1'b0;
      end else if (issuing) begin
        ram_raddr <= issue_addr;
        v0        <= 1'b1;
        idx0      <= seg_cnt;
        if (seg_cnt == SEG_W'(NUM_SEG - 1)) issuing <= 1'b0;
        else seg_cnt <= seg_cnt + 1'b1;
      end else begin
        v0 <= 1'b0;
      end
    end
  end

  assign busy_o = issuing | v0 | v1;

  assert_addr_window_R8: assert property (@(posedge clk) disable iff (rst)
    (ram_raddr >= ADDR_W'(LOW_AD)) && (ram_raddr <= ADDR_W'(DISP_TOP)))
    else $error("display read address left the window");

  // R2: a fetch walks segments downward, two nibbles per segment
  assert_addr_stride_R2: assert property (@(posedge clk) disable iff (rst)
    (issuing && !start && seg_cnt != '0) |=> (ram_raddr == ADDR_W'(int'($past(ram_raddr)) - NIBS)))
    else $error("fetch address stride wrong");
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int NUM_COM = 8,
  localparam int COM_W  = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [COM_W-1:0] com_idx,
  output logic             odd,
  output logic             running
);
  localparam logic [COM_W-1:0] LAST = COM_W'(NUM_COM - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      com_idx <= LAST;
      odd     <= 1'b1;
      running <= 1'b0;
    end else if (step) begin
      running <= 1'b1;
      if (com_idx == LAST) begin
        com_idx <= '0;
        odd     <= ~odd;
      end else begin
        com_idx <= com_idx + 1'b1;
      end
    end
  end

  assert_hold_between_steps_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(com_idx) && $stable(odd)))
    else $error("scan state moved without a step");

  assert_parity_only_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && com_idx != LAST) |=> $stable(odd))
    else $error("parity changed mid-frame");

  assert_parity_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (step && com_idx == LAST) |=> (odd != $past(odd)) && (com_idx == '0))
    else $error("wrap did not flip parity");
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG = 40,
  parameter int NUM_COM = 8,
  localparam int COM_W  = $clog2(NUM_COM)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     running,
  input  logic                     blank,
  input  logic                     odd,
  input  logic [COM_W-1:0]         com_idx,
  input  logic [NUM_SEG-1:0]       row,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
  lvl_t com_q [NUM_COM];
  lvl_t seg_q [NUM_SEG];
  logic [NUM_COM-1:0] sel_vec;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_COM; c++) begin
      if (rst || blank || !running) com_q[c] <= LVL_VDD;
      else com_q[c] <= com_code(com_idx == COM_W'(c), odd);
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      if (rst || blank || !running) seg_q[s] <= LVL_VDD;
      else seg_q[s] <= seg_code(row[s], odd);
    end
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_lvl[c*LVL_W +: LVL_W] = com_q[c];
    assign sel_vec[c] = (com_q[c] == LVL_GND) || (com_q[c] == LVL_VDD);

    assert_com_range_R8: assert property (@(posedge clk) disable iff (rst)
      com_q[c] <= LVL_VDD) else $error("common code out of range");
    assert_com_blank_R7: assert property (@(posedge clk) disable iff (rst)
      blank |=> com_q[c] == LVL_VDD) else $error("common not blanked");
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_lvl[s*LVL_W +: LVL_W] = seg_q[s];

    assert_seg_range_R8: assert property (@(posedge clk) disable iff (rst)
      seg_q[s] <= LVL_VDD) else $error("segment code out of range");
    assert_seg_blank_R7: assert property (@(posedge clk) disable iff (rst)
      blank |=> seg_q[s] == LVL_VDD) else $error("segment not blanked");
  end

  assert_one_selected_R4: assert property (@(posedge clk) disable iff (rst)
    (running && !blank) |=> $countones(sel_vec) == 1)
    else $error("not exactly one common selected");
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG  = 40,
  parameter int NUM_COM  = 8,
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 8,
  parameter int DISP_TOP = 255
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scan_en,
  input  logic                     blank_i,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic [ADDR_W-1:0]        ram_raddr,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
  localparam int COM_W = $clog2(NUM_COM);
  localparam logic [COM_W-1:0] LAST = COM_W'(NUM_COM - 1);

  logic               boot;
  logic               fetch_busy;
  logic [NUM_SEG-1:0] fetch_row, cur_row;
  logic [COM_W-1:0]   com_idx, nxt1, nxt2, target;
  logic               odd, running, start;

  function automatic logic [COM_W-1:0] wrap_inc(input logic [COM_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    nxt1   = wrap_inc(com_idx);
    nxt2   = wrap_inc(nxt1);
    target = boot ? nxt1 : nxt2;
    start  = boot | scan_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot    <= 1'b1;
      cur_row <= '0;
    end else begin
      boot <= 1'b0;
      if (scan_en) cur_row <= fetch_row;
    end
  end

  lcd_scan_ctrl #(.NUM_COM(NUM_COM)) u_scan (
    .clk(clk), .rst(rst), .step(scan_en),
    .com_idx(com_idx), .odd(odd), .running(running)
  );

  lcd_row_fetch #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .DISP_TOP(DISP_TOP)
  ) u_fetch (
    .clk(clk), .rst(rst), .start(start), .target_com(target),
    .ram_rdata(ram_rdata), .ram_raddr(ram_raddr),
    .busy_o(fetch_busy), .row(fetch_row)
  );

  lcd_level_enc #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_enc (
    .clk(clk), .rst(rst), .running(running), .blank(blank_i),
    .odd(odd), .com_idx(com_idx), .row(cur_row),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  assert_step_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> !fetch_busy)
    else $error("scan step arrived before the row fetch finished");
endmodule

// File: tb/lcd_mux_driver_tb_top.sv
module lcd_mux_driver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 50;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_en = 1'b0;
  logic         blank_i = 1'b0;
  logic [3:0]   ram_rdata = 4'h0;
  logic [7:0]   ram_raddr;
  logic [23:0]  com_lvl;
  logic [119:0] seg_lvl;

  logic [3:0] mem       [256];
  logic [3:0] fetch_mem [256];
  logic [3:0] shown_mem [256];

  int checks = 0, errors = 0, addr_bad = 0;
  int ecom = 7, eodd = 1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ram_rdata <= mem[ram_raddr];
  always @(negedge clk) if (!rst && (ram_raddr < 8'hB0)) addr_bad++;

  lcd_mux_driver dut_i (
    .clk(clk), .rst(rst), .scan_en(scan_en), .blank_i(blank_i),
    .ram_rdata(ram_rdata), .ram_raddr(ram_raddr),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [2:0] f_com(int sel, int odd);
    if (sel != 0) return (odd != 0) ? 3'd0 : 3'd5;
    return (odd != 0) ? 3'd4 : 3'd1;
  endfunction

  function automatic logic [2:0] f_seg(logic on, int odd);
    if (on) return (odd != 0) ? 3'd5 : 3'd0;
    return (odd != 0) ? 3'd2 : 3'd3;
  endfunction

  function automatic logic [23:0] exp_com();
    logic [23:0] v;
    for (int c = 0; c < 8; c++) v[c*3 +: 3] = f_com(int'(c == ecom), eodd);
    return v;
  endfunction

  // R2 mapping: commons 0..3 from FFH-2s-1, commons 4..7 from FFH-2s
  function automatic logic [119:0] exp_seg();
    logic [119:0] v;
    for (int s = 0; s < 40; s++) begin
      int a = 255 - 2*s - ((ecom < 4) ? 1 : 0);
      v[s*3 +: 3] = f_seg(shown_mem[a][ecom % 4], eodd);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [23:0] ec, input logic [119:0] es);
    checks++;
    if (com_lvl !== ec) begin
      errors++;
      $display("FAIL %s commons got %h expected %h", req, com_lvl, ec);
    end
    checks++;
    if (seg_lvl !== es) begin
      errors++;
      $display("FAIL %s segments got %h expected %h", req, seg_lvl, es);
    end
  endtask

  task automatic fill(input int pat);
    for (int a = 0; a < 256; a++) begin
      case (pat)
        0: mem[a] = 4'hF;
        1: mem[a] = 4'h0;
        2: mem[a] = a[0] ? 4'h5 : 4'hA;
        3: mem[a] = ~mem[a];
        default: mem[a] = 4'($urandom);
      endcase
    end
  endtask

  // wait the spacing, optionally change RAM while the fetcher is idle, pulse, then sample
  task automatic step(input int pat, input string req);
    repeat (GAP - 2) @(negedge clk);
    if (pat >= 0) fill(pat);
    scan_en = 1'b1;
    @(negedge clk);
    scan_en = 1'b0;
    shown_mem = fetch_mem;
    fetch_mem = mem;
    if (ecom == 7) begin ecom = 0; eodd ^= 1; end else ecom++;
    @(negedge clk);
    if (blank_i) check(req, {8{3'd5}}, {40{3'd5}});
    else check(req, exp_com(), exp_seg());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1CD5);
    fill(4);
    fetch_mem = mem;
    shown_mem = mem;
    repeat (3) @(negedge clk);
    check("R1 in reset", {8{3'd5}}, {40{3'd5}});
    rst = 1'b0;
    repeat (60) @(negedge clk);
    check("R1 before first step", {8{3'd5}}, {40{3'd5}});

    // R3 R4 R5 R6: first frame even, random contents
    for (int i = 0; i < 8; i++) step(-1, "R3 R4 R5 random even frame");
    for (int i = 0; i < 8; i++) step(i == 2 ? 4 : -1, "R6 R2 odd frame");
    // directed patterns; each change shows at the second step (R9)
    step(0, "R9 first step after change keeps old row");
    for (int i = 0; i < 5; i++) step(-1, "R5 all pixels on");
    step(1, "R9 lag");
    for (int i = 0; i < 5; i++) step(-1, "R5 all pixels off");
    step(2, "R9 lag");
    for (int i = 0; i < 9; i++) step(-1, "R2 checkerboard mapping");
    step(3, "R9 inverted contents lag");
    step(-1, "R9 inverted contents shown");

    // R7 blanking
    @(negedge clk);
    blank_i = 1'b1;
    @(negedge clk);
    check("R7 blank forces VDD", {8{3'd5}}, {40{3'd5}});
    step(-1, "R7 step while blanked");
    step(-1, "R7 step while blanked");
    @(negedge clk);
    blank_i = 1'b0;
    @(negedge clk);
    check("R7 scan kept position", exp_com(), exp_seg());
    for (int i = 0; i < 4; i++) step(4, "R2 R9 random refresh");
    for (int i = 0; i < 3; i++) step(-1, "R4 R5 tail");

    checks++;
    if (addr_bad != 0) begin
      errors++;
      $display("FAIL R8 read address below window in %0d cycles, expected 0", addr_bad);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule